// File: doc/BRIEF.md
# External Watchdog Monitor with Keyed Service

This block watches over software running elsewhere on the chip and drives an active-high failure output to outside logic when that software stops behaving. Software reaches it through a byte-wide register bus with two addresses. Address 0 holds a small control register. Address 1 is a write-only service port.

Software arms the monitor once, with a single write to the control register. That write also fixes the polarity of an external monitor input and decides whether that input is honoured. From the moment of arming, a cycle counter runs. Software must keep restarting it with a two-byte key: 0xB4 first, then 0x2C, with the second byte arriving within a bounded number of cycles of the first.

A wrong byte, a late second byte, a counter timeout, or a key that completes while the enabled monitor input is asserted all raise the failure output. Once raised, the output stays high until reset.

Top module: `ewd_monitor`

## Requirements
- R1: After reset, `fault_out` is 0 and the control register reads 0x00.
- R2: Reading address 0 returns {5'b0, in_en, in_pol, run}, with run in bit 0, in_pol in bit 1 and in_en in bit 2. Reading address 1 always returns 0x00.
- R3: Only the first control write after reset takes effect. Every later control write is ignored, and the readback keeps the first value.
- R4: While run is 0, service writes and elapsed time never raise `fault_out`. If the first control write has bit 0 clear, the block stays disabled until reset.
- R5: The first control write with bit 0 set clears the counter and leaves `fault_out` at 0. After that, each valid key (0xB4 then 0x2C) restarts the count, so regular servicing keeps `fault_out` low indefinitely.
- R6: While running, a service write other than 0xB4 that arrives while the checker is waiting for a first byte raises `fault_out` at the clock edge that takes the write.
- R7: While running, a second byte other than 0x2C raises `fault_out` at the clock edge that takes the write.
- R8: A second byte taken 1 to SVC_TIME cycles after the first byte is accepted. At SVC_TIME+1 cycles or later, the checker has already gone back to waiting for 0xB4, so a 0x2C raises `fault_out`.
- R9: With no valid key, `fault_out` rises exactly TIMEOUT cycles after the arming write. Once high, it stays high until reset, even if a valid key follows.
- R10: With in_en set, the monitor input counts as asserted when it is low (in_pol = 0) or when it is high (in_pol = 1). A key that completes while the input is asserted raises `fault_out`.
- R11: With in_en clear, the level of the monitor input has no effect on servicing.
- R12: Once the window has expired, a fresh 0xB4 followed in time by 0x2C is a valid service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 1 | Register select: 0 = control, 1 = service |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| mon_in | input | 1 | External monitor input |
| fault_out | output | 1 | Failure indication, active high |

## Verification
The assertions check on every cycle the properties that hold at all times:
- a disabled block keeps its counter at zero and its output low;
- the control register never changes once locked;
- the service address reads zero;
- a raised failure stays raised;
- a rejected key byte is always followed by a raised output;
- a counter at its limit always comes with a raised output.

Only the bench scenarios can show the exact cycle counts:
- the timeout edge;
- the last cycle of the key window that is still accepted and the first that is too late;
- how each polarity setting of the monitor input interacts with a completed key.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'hB4;
    localparam logic [7:0] KEY_SECOND = 8'h2C;
    localparam int         CTL_BITS   = 3;

    // packed: in_en is bit 2, in_pol bit 1, run bit 0
    typedef struct packed {
        logic in_en;
        logic in_pol;
        logic run;
    } ctl_t;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_st_e;
endpackage

// File: rtl/ewd_ctl.sv
module ewd_ctl
    import ewd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctl,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output logic       locked,
    output logic       arm
);
    typedef struct packed {
        ctl_t ctl;
        logic locked;
    } ctl_state_t;

    ctl_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        arm = 1'b0;
        if (wr_ctl && !r_q.locked) begin
            r_d.locked = 1'b1;
            r_d.ctl    = ctl_t'(wdata[CTL_BITS-1:0]);
            arm        = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctl    = r_q.ctl;
    assign locked = r_q.locked;
endmodule

// File: rtl/ewd_key.sv
module ewd_key
    import ewd_pkg::*;
#(
    parameter int SVC_TIME = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       wr_svc,
    input  logic [7:0] wdata,
    output logic       good,
    output logic       bad
);
    localparam int WIN_W = $clog2(SVC_TIME + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(SVC_TIME - 1);

    typedef struct packed {
        key_st_e          st;
        logic [WIN_W-1:0] win;
    } key_state_t;

    key_state_t k_d, k_q;

    always_comb begin
        k_d  = k_q;
        good = 1'b0;
        bad  = 1'b0;
        if (!en) begin
            k_d.st  = KEY_IDLE;
            k_d.win = '0;
        end else begin
            unique case (k_q.st)
                KEY_IDLE: begin
                    if (wr_svc) begin
                        if (wdata == KEY_FIRST) begin
                            k_d.st  = KEY_ARMED;
                            k_d.win = '0;
                        end else begin
                            bad = 1'b1;
                        end
                    end
                end
                KEY_ARMED: begin
                    if (wr_svc) begin
                        k_d.st = KEY_IDLE;
                        if (wdata == KEY_SECOND) good = 1'b1;
                        else                     bad  = 1'b1;
                    end else if (k_q.win == WIN_LAST) begin
                        k_d.st = KEY_IDLE;
                    end else begin
                        k_d.win = k_q.win + 1'b1;
                    end
                end
                default: k_d.st = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '{st: KEY_IDLE, win: '0};
        else        k_q <= k_d;
    end
endmodule

// File: rtl/ewd_timer.sv
module ewd_timer #(
    parameter int TIMEOUT = 1000,
    localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             arm,
    input  logic             good,
    input  logic             bad,
    input  logic             mon_act,
    output logic             fault,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } tmr_state_t;

    tmr_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (arm) begin
            t_d.cnt   = '0;
            t_d.fault = 1'b0;
        end else if (en) begin
            if (good)                t_d.cnt = '0;
            else if (t_q.cnt != LIMIT) t_d.cnt = t_q.cnt + 1'b1;
            if (bad || (good && mon_act) || (t_d.cnt == LIMIT))
                t_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign fault = t_q.fault;
    assign cnt   = t_q.cnt;
endmodule

// File: rtl/ewd_monitor.sv
module ewd_monitor
    import ewd_pkg::*;
#(
    parameter int TIMEOUT  = 1000,
    parameter int SVC_TIME = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       mon_in,
    output logic       fault_out
);
    localparam logic ADDR_CTL = 1'b0;
    localparam int   CNT_W    = $clog2(TIMEOUT + 1);

    ctl_t             ctl;
    logic             locked;
    logic             arm;
    logic             svc_good;
    logic             svc_bad;
    logic             mon_act;
    logic [CNT_W-1:0] tmr_cnt;

    ewd_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctl (bus_we && bus_addr == ADDR_CTL),
        .wdata  (bus_wdata),
        .ctl    (ctl),
        .locked (locked),
        .arm    (arm)
    );

    ewd_key #(.SVC_TIME(SVC_TIME)) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl.run),
        .wr_svc (bus_we && bus_addr != ADDR_CTL),
        .wdata  (bus_wdata),
        .good   (svc_good),
        .bad    (svc_bad)
    );

    assign mon_act = ctl.in_en && (ctl.in_pol ? mon_in : !mon_in);

    ewd_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctl.run),
        .arm     (arm),
        .good    (svc_good),
        .bad     (svc_bad),
        .mon_act (mon_act),
        .fault   (fault_out),
        .cnt     (tmr_cnt)
    );

    assign bus_rdata = (bus_addr == ADDR_CTL) ? {{(8-CTL_BITS){1'b0}}, ctl} : 8'h00;
endmodule

// File: rtl/ewd_monitor_chk.sv
module ewd_monitor_chk #(
    parameter int TIMEOUT = 1000,
    localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_addr,
    input logic [7:0]       bus_rdata,
    input logic             fault_out,
    input logic             run,
    input logic             locked,
    input logic [2:0]       ctl_bits,
    input logic             bad,
    input logic [CNT_W-1:0] cnt
);
    // R2
    svc_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr |-> bus_rdata == 8'h00);

    // R3
    ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(ctl_bits));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!fault_out && cnt == '0));

    // R6
    bad_key_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> fault_out);

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_out && run) |=> fault_out);

    // R9
    limit_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(TIMEOUT)) |-> fault_out);
endmodule

bind ewd_monitor ewd_monitor_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .fault_out (fault_out),
    .run       (ctl.run),
    .locked    (locked),
    .ctl_bits  (ctl),
    .bad       (svc_bad),
    .cnt       (tmr_cnt)
);

// File: tb/ewd_monitor_tb.sv
module ewd_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 64;
    localparam int SVC        = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mon_in = 1'b1;
    logic       fault_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ewd_monitor #(.TIMEOUT(TO), .SVC_TIME(SVC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mon_in    (mon_in),
        .fault_out (fault_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        bus_we = 1'b0;
        mon_in = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_ctl(output logic [7:0] v);
        bus_addr = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic service();
        wr(1'b1, 8'hB4);
        wr(1'b1, 8'h2C);
    endtask

    task automatic t_reset_and_read();
        logic [7:0] v;
        do_reset();
        read_ctl(v);
        check("R1 ctl after reset", v, 8'h00);
        check("R1 fault after reset", {7'b0, fault_out}, 8'h00);
        wr(1'b0, 8'hFF);
        read_ctl(v);
        check("R2 ctl upper bits zero", v, 8'h07);
        bus_addr = 1'b1;
        #1 check("R2 service reads zero", bus_rdata, 8'h00);
        wr(1'b0, 8'h00);
        read_ctl(v);
        check("R3 second ctl write ignored", v, 8'h07);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        do_reset();
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h01);
        read_ctl(v);
        check("R4 ctl stays disabled", v, 8'h00);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hB4);
        wr(1'b1, 8'h11);
        idle(TO + 10);
        check("R4 no fault when disabled", {7'b0, fault_out}, 8'h00);
    endtask

    task automatic t_periodic();
        do_reset();
        wr(1'b0, 8'h01);
        check("R5 fault low after arm", {7'b0, fault_out}, 8'h00);
        for (int i = 0; i < 5; i++) begin
            idle(TO - 20);
            service();
        end
        check("R5 periodic service keeps low", {7'b0, fault_out}, 8'h00);
    endtask

    task automatic t_bad_first();
        do_reset();
        wr(1'b0, 8'h01);
        check("R6 pre", {7'b0, fault_out}, 8'h00);
        wr(1'b1, 8'hB5);
        check("R6 wrong first byte", {7'b0, fault_out}, 8'h01);
    endtask

    task automatic t_bad_second();
        do_reset();
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hB4);
        check("R7 pre", {7'b0, fault_out}, 8'h00);
        wr(1'b1, 8'h2D);
        check("R7 wrong second byte", {7'b0, fault_out}, 8'h01);
    endtask

    task automatic t_window();
        do_reset();
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hB4);
        idle(SVC - 1);
        wr(1'b1, 8'h2C);
        check("R8 second byte at last window cycle", {7'b0, fault_out}, 8'h00);
        do_reset();
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hB4);
        idle(SVC);
        wr(1'b1, 8'h2C);
        check("R8 second byte one cycle late", {7'b0, fault_out}, 8'h01);
    endtask

    task automatic t_timeout();
        do_reset();
        wr(1'b0, 8'h01);
        idle(TO - 1);
        check("R9 one cycle before timeout", {7'b0, fault_out}, 8'h00);
        idle(1);
        check("R9 timeout edge", {7'b0, fault_out}, 8'h01);
        service();
        idle(3);
        check("R9 fault sticky after service", {7'b0, fault_out}, 8'h01);
    endtask

    task automatic t_polarity();
        do_reset();
        wr(1'b0, 8'h05);
        mon_in = 1'b1;
        service();
        check("R10 low-active, input high", {7'b0, fault_out}, 8'h00);
        mon_in = 1'b0;
        service();
        check("R10 low-active, input low", {7'b0, fault_out}, 8'h01);
        do_reset();
        wr(1'b0, 8'h07);
        mon_in = 1'b0;
        service();
        check("R10 high-active, input low", {7'b0, fault_out}, 8'h00);
        mon_in = 1'b1;
        service();
        check("R10 high-active, input high", {7'b0, fault_out}, 8'h01);
    endtask

    task automatic t_input_off();
        do_reset();
        wr(1'b0, 8'h01);
        mon_in = 1'b0;
        service();
        check("R11 input ignored when off", {7'b0, fault_out}, 8'h00);
        wr(1'b0, 8'h03);
        mon_in = 1'b1;
        service();
        check("R11 input ignored, later ctl write", {7'b0, fault_out}, 8'h00);
    endtask

    task automatic t_rearm_key();
        do_reset();
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hB4);
        idle(SVC + 3);
        check("R12 expiry alone no fault", {7'b0, fault_out}, 8'h00);
        service();
        check("R12 fresh key after expiry", {7'b0, fault_out}, 8'h00);
    endtask

    initial begin
        t_reset_and_read();
        t_disabled();
        t_periodic();
        t_bad_first();
        t_bad_second();
        t_window();
        t_timeout();
        t_polarity();
        t_input_off();
        t_rearm_key();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule